// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block chooses which physical page frame to evict when a page miss occurs. Each frame of a small, fully associative frame set has a recent-use flag. A reference strobe with a frame index sets the flag of that frame. A single circular hand pointer moves over the frames only while a miss is being served. Frames whose flag is set lose the flag and stay resident. The first frame found with a clear flag is reported as the victim, together with a one-cycle done strobe.

The surrounding logic then installs the new page and pulses the fill strobe. The fill puts the page into the reported frame with its flag clear, and it parks the hand on the next frame, which holds the oldest resident page. The block deals only in frame indices. It has no page table, no address tags, no dirty tracking and no backing-store transfers. Right after reset the frames are empty, and misses take them in index order with no sweep.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset `busy` and `victim_valid` are low, all frames are empty, and the hand rests on frame 0.
- R2: While empty frames remain, each miss returns the next empty frame in ascending index order (0, 1, …, NUM_FRAMES-1). `victim_valid` is high in the cycle that follows the clock edge that accepted the miss.
- R3: The sweep examines one frame per clock. Each frame skipped because its flag was set delays `victim_valid` by exactly one cycle beyond the R2 timing.
- R4: A frame examined with its flag set has the flag cleared and stays resident. The victim is the first frame in circular order from the hand whose flag is clear.
- R5: If every flag is set when the miss arrives, the sweep clears all flags, wraps around, and returns the frame the hand started on, after NUM_FRAMES skip cycles. The sweep always ends.
- R6: A fill sets the hand to the frame after the victim, wrapping from NUM_FRAMES-1 to 0. The next miss starts examining there.
- R7: A filled frame starts with its flag clear, even when a reference to that frame arrives in the same cycle as the fill.
- R8: A reference to the frame being examined in the same sweep cycle wins over the sweep's clear, so that frame keeps its flag.
- R9: A reference to a frame that holds no page has no effect on that frame's flag.
- R10: `miss_req` is ignored while `busy` is high. `fill_valid` is ignored unless a reported victim is waiting for its fill.
- R11: `victim_valid` is a single-cycle pulse. `busy` stays high from the edge that accepts a miss until the edge that accepts the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference strobe |
| ref_idx | input | IDX_W | Frame index of the reference |
| miss_req | input | 1 | Miss request, accepted when `busy` is low |
| fill_valid | input | 1 | Install the new page into the reported victim frame |
| victim_valid | output | 1 | One-cycle done strobe with the victim index |
| victim_idx | output | IDX_W | Frame chosen for replacement |
| busy | output | 1 | Miss in progress or waiting for its fill |

## Verification
The hardest case to reach from the ports is a reference that lands on the exact frame the hand is examining in that cycle. The bench sets every flag so that the sweep runs a known number of cycles. It then drives the reference in the second sweep cycle, aimed at the frame after the starting hand. The effect shows up one miss later: the kept flag adds a skip cycle and moves the next victim on by one frame. The bench also walks every one of the sixteen flag patterns, with the hand starting at different positions, against an arithmetic model of the sweep.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic [1:0] {
    HAND_IDLE = 2'd0,
    HAND_SCAN = 2'd1,
    HAND_HOLD = 2'd2
  } hand_state_e;
endpackage

// File: rtl/use_flag_bank.sv
module use_flag_bank #(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_use
);
  logic [NUM_FRAMES-1:0] use_q;
  logic [NUM_FRAMES-1:0] occ_q;

  // Per-frame flag: install beats reference, reference beats sweep clear.
  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    always_ff @(posedge clk) begin
      if (rst) begin
        use_q[f] <= 1'b0;
        occ_q[f] <= 1'b0;
      end else if (inst_en && inst_idx == IDX_W'(f)) begin
        use_q[f] <= 1'b0;
        occ_q[f] <= 1'b1;
      end else if (ref_valid && ref_idx == IDX_W'(f) && occ_q[f]) begin
        use_q[f] <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(f)) begin
        use_q[f] <= 1'b0;
      end
    end
  end

  assign rd_use = use_q[rd_idx];

  // R8
  ref_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && occ_q[ref_idx] && !(inst_en && inst_idx == ref_idx))
      |=> use_q[$past(ref_idx)]);

  // R7
  fill_clear_chk: assert property (@(posedge clk) disable iff (rst)
    inst_en |=> (!use_q[$past(inst_idx)] && occ_q[$past(inst_idx)]));

  // R4
  sweep_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(ref_valid && ref_idx == clr_idx) && !(inst_en && inst_idx == clr_idx))
      |=> !use_q[$past(clr_idx)]);

  // R9
  empty_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && !occ_q[ref_idx] && !(inst_en && inst_idx == ref_idx))
      |=> !use_q[$past(ref_idx)]);
endmodule

// File: rtl/clock_hand_fsm.sv
module clock_hand_fsm
  import clock_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_req,
  input  logic             fill_valid,
  input  logic             rd_use,
  output logic [IDX_W-1:0] rd_idx,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             inst_en,
  output logic [IDX_W-1:0] inst_idx,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx,
  output logic             busy
);
  localparam int CNT_W = $clog2(NUM_FRAMES + 2);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  hand_state_e      st_q;
  logic [IDX_W-1:0] hand_q;
  logic             scan;
  logic [CNT_W-1:0] sweep_cnt;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] h);
    return (h == LAST) ? '0 : h + 1'b1;
  endfunction

  assign scan     = (st_q == HAND_IDLE && miss_req) || (st_q == HAND_SCAN);
  assign rd_idx   = hand_q;
  assign clr_en   = scan && rd_use;
  assign clr_idx  = hand_q;
  assign inst_en  = (st_q == HAND_HOLD) && fill_valid;
  assign inst_idx = victim_idx;
  assign busy     = (st_q != HAND_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= HAND_IDLE;
      hand_q       <= '0;
      victim_valid <= 1'b0;
      victim_idx   <= '0;
    end else begin
      victim_valid <= 1'b0;
      if (scan) begin
        if (rd_use) begin
          hand_q <= step(hand_q);
          st_q   <= HAND_SCAN;
        end else begin
          victim_valid <= 1'b1;
          victim_idx   <= hand_q;
          st_q         <= HAND_HOLD;
        end
      end else if (inst_en) begin
        hand_q <= step(victim_idx);
        st_q   <= HAND_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sweep_cnt <= '0;
    else if (st_q == HAND_SCAN) sweep_cnt <= sweep_cnt + 1'b1;
    else sweep_cnt <= '0;
  end

  // R5
  sweep_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_cnt <= CNT_W'(NUM_FRAMES));

  // R11
  victim_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid);

  // R11
  victim_busy_chk: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> busy);

  // R10
  hold_no_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == HAND_HOLD && !fill_valid) |=> !victim_valid);
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             miss_req,
  input  logic             fill_valid,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx,
  output logic             busy
);
  logic             rd_use;
  logic [IDX_W-1:0] rd_idx;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic             inst_en;
  logic [IDX_W-1:0] inst_idx;

  use_flag_bank #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) i_flags (
    .clk(clk), .rst(rst),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .inst_en(inst_en), .inst_idx(inst_idx),
    .rd_idx(rd_idx), .rd_use(rd_use)
  );

  clock_hand_fsm #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) i_hand (
    .clk(clk), .rst(rst),
    .miss_req(miss_req), .fill_valid(fill_valid),
    .rd_use(rd_use), .rd_idx(rd_idx),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .inst_en(inst_en), .inst_idx(inst_idx),
    .victim_valid(victim_valid), .victim_idx(victim_idx),
    .busy(busy)
  );
endmodule

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;
  localparam int NF = 4;
  localparam int IW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_valid = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic miss_req = 1'b0;
  logic fill_valid = 1'b0;
  logic victim_valid;
  logic [IW-1:0] victim_idx;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  bit m_use [NF];
  bit m_occ [NF];
  int m_hand = 0;
  int last_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(NF)) i_clock_victim_sel (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .miss_req(miss_req), .fill_valid(fill_valid),
    .victim_valid(victim_valid), .victim_idx(victim_idx), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_ref(input int idx);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = IW'(idx);
    @(negedge clk);
    ref_valid = 1'b0;
    if (m_occ[idx]) m_use[idx] = 1;
  endtask

  // Miss with optional reference injected at the negedge after accept edge + inj_at.
  task automatic do_miss(input int inj_at, input int inj_idx, input string req);
    int exp_v, exp_lat, lat, h;
    bit found;
    h = m_hand; found = 0; exp_v = 0; exp_lat = 0;
    for (int s = 0; s < 3*NF && !found; s++) begin
      bit ref_now;
      ref_now = (s == inj_at + 1) && m_occ[inj_idx];
      if (m_use[h] && !(ref_now && inj_idx == h)) begin
        m_use[h] = 0;
        h = (h + 1) % NF;
      end else if (m_use[h]) begin
        h = (h + 1) % NF;
      end else begin
        found = 1; exp_v = h; exp_lat = s;
      end
      if (ref_now) m_use[inj_idx] = 1;
    end
    m_hand = h;
    @(negedge clk);
    miss_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    miss_req = 1'b0;
    lat = 0;
    while (!victim_valid && lat < 3*NF) begin
      if (lat == inj_at) begin ref_valid = 1'b1; ref_idx = IW'(inj_idx); end
      @(posedge clk);
      @(negedge clk);
      ref_valid = 1'b0;
      lat++;
    end
    chk(victim_valid == 1'b1 && lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(victim_idx == IW'(exp_v), {req, " victim"}, int'(victim_idx), exp_v);
    @(negedge clk);
    chk(victim_valid == 1'b0, "R11 pulse", int'(victim_valid), 0);
    chk(busy == 1'b1, "R11 busy", int'(busy), 1);
    last_v = exp_v;
  endtask

  task automatic do_fill(input bit ref_same);
    @(negedge clk);
    fill_valid = 1'b1;
    if (ref_same) begin ref_valid = 1'b1; ref_idx = IW'(last_v); end
    @(negedge clk);
    fill_valid = 1'b0; ref_valid = 1'b0;
    chk(busy == 1'b0, "R11 busy clear", int'(busy), 0);
    m_use[last_v] = 0; m_occ[last_v] = 1;
    m_hand = (last_v + 1) % NF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_use[i] = 0; m_occ[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(victim_valid == 1'b0, "R1 victim_valid", int'(victim_valid), 0);

    // R9: reference to empty frame 2 must not set its flag
    do_ref(2);
    // R2: empty frames taken in order without sweep
    for (int i = 0; i < NF; i++) begin
      do_miss(-5, 0, "R2");
      do_fill(0);
    end
    chk(last_v == NF - 1, "R9 empty ref", last_v, NF - 1);

    // R3 R4 R5 R6: every flag pattern
    for (int mask = 0; mask < 16; mask++) begin
      for (int f = 0; f < NF; f++) if (mask[f]) do_ref(f);
      do_miss(-5, 0, mask == 15 ? "R5" : "R4");
      do_fill(0);
    end
    // Second pass with a shifted hand
    for (int mask = 15; mask >= 0; mask -= 3) begin
      for (int f = 0; f < NF; f++) if (mask[f]) do_ref(f);
      do_miss(-5, 0, "R3");
      do_fill(0);
    end

    // R8: reference to the frame examined in the second sweep cycle
    for (int f = 0; f < NF; f++) do_ref(f);
    do_miss(0, (m_hand + 1) % NF, "R8 sweep");
    do_fill(0);
    do_miss(-5, 0, "R8 kept flag");
    do_fill(0);

    // R7: reference in the fill cycle loses to the fill
    for (int f = 0; f < NF; f++) do_ref(f);
    do_miss(-5, 0, "R7 setup");
    do_fill(1);
    for (int f = 0; f < NF; f++) if (f != last_v) do_ref(f);
    do_miss(-5, 0, "R7");
    do_fill(0);

    // R10: miss while busy ignored; stray fill while idle ignored
    do_miss(-5, 0, "R10 setup");
    @(negedge clk); miss_req = 1'b1;
    @(negedge clk); miss_req = 1'b0;
    @(negedge clk);
    chk(victim_valid == 1'b0, "R10 miss ignored", int'(victim_valid), 0);
    do_fill(0);
    for (int f = 0; f < NF; f++) do_ref(f);
    @(negedge clk); fill_valid = 1'b1;
    @(negedge clk); fill_valid = 1'b0;
    do_miss(-5, 0, "R10 stray fill");
    do_fill(0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule